// File: doc/BRIEF.md
# Serial Digital Audio Subframe Transmitter

This block turns a stream of 32-bit audio words, pulled one at a time from a transmit FIFO, into a serial line in the consumer digital audio interface format. Each frame has two 32-slot subframes. A subframe opens with a four-slot sync preamble. The other 28 slots are biphase-mark coded, with two half-cells per slot. Each audio word supplies a 24-bit sample, three status bits and, optionally, its own parity bit.

The transmitter runs from a single core clock. It paces half-cells with a clamped programmable divider, so one field sets the output sample rate. The configuration inputs come straight from a control register. Through them software can:
- choose between two-channel and single-channel operation;
- choose whether the parity slot is computed by the block or copied from the word;
- hold back the first block-start preamble by a programmed number of frames.

A word needed while the FIFO is empty is replaced by zeros, and a one-cycle underrun pulse reports it.

Top module: `spdif_tx`

## Requirements
- R1: A half-cell lasts max(cfg_rate,3)+1 core clock cycles, so a frame (128 half-cells) lasts 128·(max(cfg_rate,3)+1) cycles. Rate values 0, 1 and 2 behave exactly like 3.
- R2: Whenever cfg_enable or cfg_tx_mode is 0, the transmitter is held at its start point. While held, line_out is low from the next clock, fifo_rd and underrun stay 0, and FIFO contents are untouched. Running again restarts at half-cell 0 of the left subframe of frame 0.
- R3: In two-channel mode, exactly one word is requested per subframe. fifo_rd is high for one cycle, in the clock at whose edge the subframe's first half-cell is registered onto line_out. It is high only when fifo_empty is 0.
- R4: A request made while fifo_empty is 1 produces no read. Instead underrun is high for that one cycle, and the subframe carries all-zero slots 4 to 30.
- R5: Half-cells 0 to 7 of a subframe carry the preamble, MSB first: block start 8'hE8, left 8'hE2, right 8'hE4. The pattern is inverted when line_out was high just before the subframe began.
- R6: Slots 4 to 30 are biphase-mark coded. Each slot's first half-cell inverts the previous line level, and its second half-cell inverts again only for a 1. Slot 4+k carries word bit k for k = 0 to 26: sample bits 23:0 LSB first, then the validity, user and channel-status bits in word bits 24, 25 and 26.
- R7: When cfg_parity_gen is 1, slot 31 is the XOR of word bits 26:0, so slots 4 to 31 hold an even number of ones. When it is 0, slot 31 is word bit 27 unchanged. Word bits 31:28 are ignored.
- R8: The hold is d = cfg_hold_count when cfg_hold_first_b is 1 and 0 otherwise. Counting frames from the run start, frame f uses the block-start preamble in its left subframe when f ≥ d and (f−d) mod 192 = 0. Other left subframes use the left preamble, and right subframes always use the right preamble.
- R9: When cfg_mono is 1, one word is requested per frame, at the start of the left subframe. With cfg_mono_left = 1 the left subframe carries that word; with cfg_mono_left = 0 the right subframe carries it. The other subframe carries all-zero slots 4 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rate | input | 8 | Half-cell divider field (clamped to at least 3) |
| cfg_enable | input | 1 | Transmitter enable; 0 holds the logic at its start point |
| cfg_tx_mode | input | 1 | Must be 1 (transmit direction) for the block to run |
| cfg_parity_gen | input | 1 | 1: compute parity slot; 0: copy word bit 27 |
| cfg_mono | input | 1 | 1: single-channel operation |
| cfg_mono_left | input | 1 | Single-channel: 1 left subframe carries the sample, 0 right |
| cfg_hold_first_b | input | 1 | 1: delay the first block-start preamble |
| cfg_hold_count | input | 13 | Number of frames to delay the first block start |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rdata | input | 32 | Word at the FIFO head (shown ahead of the read) |
| fifo_rd | output | 1 | Pops the head word |
| underrun | output | 1 | One-cycle pulse: a word was needed from an empty FIFO |
| line_out | output | 1 | Serial biphase-mark line |

## Verification
The reference model recomputes every half-cell from the clock count since run start, so faults show up at the ports within a short, bounded time.
- A wrong half-cell or subframe counter moves a fifo_rd pulse or a preamble edge, and this is visible on line_out within one half-cell.
- A wrong frame or hold counter sends the block-start pattern in the wrong frame. The mismatch appears within the first eight half-cells of that frame.
- A stale latched word or a wrong parity choice corrupts the data half-cells of the affected subframe.
- A flipped line-level register inverts the next preamble.
- A divider that does not clamp shortens every half-cell from the first one onward.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int WORD_W     = 32;
  localparam int PAR_BIT    = 27;
  localparam int HALF_W     = 6;   // 64 half-cells per subframe
  localparam int PRE_HALVES = 8;

  typedef enum logic [1:0] {PRE_BLOCK, PRE_LEFT, PRE_RIGHT} pre_kind_e;

  // Half-cell pattern of a preamble when the line was low before it.
  function automatic logic [7:0] pre_pattern(pre_kind_e k);
    case (k)
      PRE_BLOCK: return 8'b1110_1000;
      PRE_LEFT:  return 8'b1110_0010;
      default:   return 8'b1110_0100;
    endcase
  endfunction

  // Logical value carried by a data slot (4..31) of a subframe.
  function automatic logic slot_bit(logic [WORD_W-1:0] w, logic [4:0] slot, logic gen);
    logic [4:0] idx;
    idx = slot - 5'd4;
    if (slot == 5'd31) return gen ? ^w[PAR_BIT-1:0] : w[PAR_BIT];
    else if (slot >= 5'd4) return w[idx];
    else return 1'b0;
  endfunction
endpackage

// File: rtl/spdif_tx_rate_div.sv
module spdif_tx_rate_div #(
  parameter int RATE_W  = 8,
  parameter int MIN_DIV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [RATE_W-1:0] cnt;
  logic [RATE_W-1:0] lim;

  assign lim  = (rate < RATE_W'(MIN_DIV)) ? RATE_W'(MIN_DIV) : rate;
  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R1: half-cells never shorter than the clamped minimum of four cycles
  a_r1_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick ##1 !tick ##1 !tick);
endmodule

// File: rtl/spdif_tx_seq.sv
module spdif_tx_seq
  import spdif_tx_pkg::*;
#(
  parameter int HOLD_W       = 13,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              mono,
  input  logic              mono_left,
  input  logic              hold_en,
  input  logic [HOLD_W-1:0] hold_cnt,
  output logic [HALF_W-1:0] hc,
  output pre_kind_e         pre_kind,
  output logic              fetch,
  output logic              carry
);
  localparam int BLK_W = $clog2(BLOCK_FRAMES);

  logic              sub_right;
  logic [BLK_W-1:0]  blk;
  logic [HOLD_W-1:0] pd;
  logic              sub_end;

  assign sub_end  = tick && (hc == {HALF_W{1'b1}});
  assign fetch    = tick && (hc == '0) && (!mono || !sub_right);
  assign carry    = !mono || (mono_left ? !sub_right : sub_right);
  assign pre_kind = sub_right ? PRE_RIGHT :
                    ((pd == '0) && (blk == '0)) ? PRE_BLOCK : PRE_LEFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= '0; sub_right <= 1'b0; blk <= '0; pd <= '0;
    end else if (!run) begin
      hc <= '0; sub_right <= 1'b0; blk <= '0;
      pd <= hold_en ? hold_cnt : '0;
    end else if (tick) begin
      hc <= hc + 1'b1;
      if (sub_end) begin
        sub_right <= ~sub_right;
        if (sub_right) begin
          if (pd != '0) pd <= pd - 1'b1;
          else if (blk == BLK_W'(BLOCK_FRAMES - 1)) blk <= '0;
          else blk <= blk + 1'b1;
        end
      end
    end
  end

  // R8: the frame position never leaves the block
  a_r8_blk_range: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_end && sub_right && pd == '0) |=> (blk < BLK_W'(BLOCK_FRAMES)));
  // R9: single-channel mode fetches only at a left subframe start
  a_r9_mono_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && mono) |-> !sub_right);
endmodule

// File: rtl/spdif_tx_bmc.sv
module spdif_tx_bmc
  import spdif_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [HALF_W-1:0] hc,
  input  pre_kind_e         pre_kind,
  input  logic [WORD_W-1:0] word,
  input  logic              parity_gen,
  output logic              line
);
  logic       sf_start;
  logic       lvl;
  logic [7:0] pat;
  logic       base;

  always_comb begin
    pat  = pre_pattern(pre_kind);
    base = (hc == '0) ? line : sf_start;
    if (hc < HALF_W'(PRE_HALVES))
      lvl = pat[3'd7 - hc[2:0]] ^ base;
    else if (!hc[0])
      lvl = ~line;
    else
      lvl = line ^ slot_bit(word, hc[5:1], parity_gen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line <= 1'b0; sf_start <= 1'b0;
    end else if (!run) begin
      line <= 1'b0; sf_start <= 1'b0;
    end else if (tick) begin
      line <= lvl;
      if (hc == '0) sf_start <= line;
    end
  end

  // R6: every data slot opens with a line transition
  a_r6_cell_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && hc >= HALF_W'(PRE_HALVES) && !hc[0]) |=> (line != $past(line)));
  // R7: with generated parity the subframe ends at the level it started from
  a_r7_even_close: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && hc == {HALF_W{1'b1}} && parity_gen) |=> (line == sf_start));
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_tx_pkg::*;
#(
  parameter int RATE_W       = 8,
  parameter int HOLD_W       = 13,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              cfg_enable,
  input  logic              cfg_tx_mode,
  input  logic              cfg_parity_gen,
  input  logic              cfg_mono,
  input  logic              cfg_mono_left,
  input  logic              cfg_hold_first_b,
  input  logic [HOLD_W-1:0] cfg_hold_count,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic              fifo_rd,
  output logic              underrun,
  output logic              line_out
);
  logic              run;
  logic              tick;
  logic [HALF_W-1:0] hc;
  pre_kind_e         pre_kind;
  logic              fetch;
  logic              carry;
  logic [WORD_W-1:0] held_w;
  logic [WORD_W-1:0] enc_word;
  logic              unused_hi;

  assign run       = cfg_enable & cfg_tx_mode;
  assign fifo_rd   = fetch & ~fifo_empty;
  assign underrun  = fetch & fifo_empty;
  assign enc_word  = carry ? held_w : '0;
  assign unused_hi = ^fifo_rdata[WORD_W-1:PAR_BIT+1];

  spdif_tx_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .rate(cfg_rate), .tick(tick));

  spdif_tx_seq #(.HOLD_W(HOLD_W), .BLOCK_FRAMES(BLOCK_FRAMES)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .mono(cfg_mono), .mono_left(cfg_mono_left),
    .hold_en(cfg_hold_first_b), .hold_cnt(cfg_hold_count),
    .hc(hc), .pre_kind(pre_kind), .fetch(fetch), .carry(carry));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_w <= '0;
    else if (!run)     held_w <= '0;
    else if (fetch)    held_w <= fifo_empty ? '0 : {{(WORD_W-PAR_BIT-1){1'b0}}, fifo_rdata[PAR_BIT:0]};
  end

  spdif_tx_bmc u_bmc (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .hc(hc),
    .pre_kind(pre_kind), .word(enc_word), .parity_gen(cfg_parity_gen),
    .line(line_out));

  // R2: a stopped transmitter drives the line low on the next clock
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !line_out);
  // R3: a read is never issued to an empty FIFO
  a_r3_rd_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);
  // R4: underrun and read never coincide, and underrun is a single pulse
  a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !fifo_rd ##1 !underrun);
endmodule

// File: tb/spdif_tx_bench.sv
module spdif_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_rate = 8'd3;
  logic        cfg_enable = 1'b0, cfg_tx_mode = 1'b0, cfg_parity_gen = 1'b1;
  logic        cfg_mono = 1'b0, cfg_mono_left = 1'b1, cfg_hold_first_b = 1'b0;
  logic [12:0] cfg_hold_count = '0;
  logic        fifo_empty = 1'b1;
  logic [31:0] fifo_rdata = '0;
  logic        fifo_rd, underrun, line_out;

  always #5 clk = ~clk;

  spdif_tx u_spdif_tx (.*);

  int checks = 0, errors = 0;
  string cur_req = "R2";
  logic [31:0] q[$];
  bit   active = 0, pop_req = 0, done = 0;
  int   c = 0, rd_seen = 0, ur_seen = 0, cyc = 0;
  bit   line_exp = 0, sfs = 0;
  logic [31:0] mw = '0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic present();
    fifo_empty = (q.size() == 0);
    fifo_rdata = fifo_empty ? 32'h0 : q[0];
  endtask

  always @(posedge clk) begin
    #1;
    if (pop_req) begin void'(q.pop_front()); pop_req = 0; end
    present();
  end

  // Behavioural reference, evaluated between edges
  always @(negedge clk) if (active) begin
    bit run, tick, fetch, carry, isb, b, lvl, base;
    int d, n, h, sub, f, dd, slot;
    logic [7:0]  pat;
    logic [31:0] dw;
    logic [27:0] bits;
    run   = cfg_enable && cfg_tx_mode;
    d     = (cfg_rate < 3) ? 3 : cfg_rate;
    tick  = run && (c % (d + 1) == d);
    n     = c / (d + 1);
    h     = n % 64;
    sub   = (n / 64) % 2;
    f     = n / 128;
    carry = !cfg_mono || (cfg_mono_left ? sub == 0 : sub == 1);
    fetch = tick && h == 0 && (!cfg_mono || sub == 0);
    chk(fifo_rd == (fetch && !fifo_empty), "fifo_rd", fifo_rd, fetch && !fifo_empty);
    chk(underrun == (fetch && fifo_empty), "underrun", underrun, fetch && fifo_empty);
    chk(line_out == line_exp, $sformatf("line_out c=%0d", c), line_out, line_exp);
    if (fifo_rd) rd_seen++;
    if (underrun) ur_seen++;
    if (!run) begin
      line_exp = 0; sfs = 0; c = 0; mw = '0;
    end else begin
      if (tick) begin
        if (fetch) begin
          mw = fifo_empty ? 32'h0 : fifo_rdata;
          if (!fifo_empty) pop_req = 1;
        end
        dw = carry ? mw : 32'h0;
        dd = cfg_hold_first_b ? int'(cfg_hold_count) : 0;
        isb = (f >= dd) && ((f - dd) % 192 == 0);
        if (h < 8) begin
          pat  = (sub == 1) ? 8'hE4 : (isb ? 8'hE8 : 8'hE2);
          base = (h == 0) ? line_exp : sfs;
          lvl  = pat[7 - h] ^ base;
          if (h == 0) sfs = line_exp;
        end else begin
          slot = h / 2;
          bits = {cfg_parity_gen ? ^dw[26:0] : dw[27], dw[26:0]};
          b    = bits[slot - 4];
          lvl  = (h % 2 == 0) ? !line_exp : (line_exp ^ b);
        end
        line_exp = lvl;
      end
      c++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic fill(input int nw, input int seed);
    q.delete();
    for (int i = 0; i < nw; i++) q.push_back((i + seed) * 32'h9E3779B1 ^ 32'h5A5A1234);
    present();
  endtask

  task automatic phase(input string tag, input int rate, input bit gen, input bit mono,
                       input bit ml, input bit hold, input int hcnt, input int frames,
                       input int nw, input int exp_rd, input int exp_ur);
    @(posedge clk); #2;
    cfg_enable = 0; cur_req = tag;
    cfg_rate = 8'(rate); cfg_parity_gen = gen; cfg_mono = mono; cfg_mono_left = ml;
    cfg_hold_first_b = hold; cfg_hold_count = 13'(hcnt); cfg_tx_mode = 1;
    repeat (2) @(posedge clk);
    #2; fill(nw, rate * 7 + frames);
    rd_seen = 0; ur_seen = 0;
    cfg_enable = 1;
    repeat (frames * 128 * (((rate < 3) ? 3 : rate) + 1)) @(posedge clk);
    #2 cfg_enable = 0;
    repeat (2) @(posedge clk);
    chk(rd_seen == exp_rd, "read count", rd_seen, exp_rd);   // R3 / R9 word count
    chk(ur_seen == exp_ur, "underrun count", ur_seen, exp_ur); // R4
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1; active = 1;
    @(negedge clk); #1;
    cur_req = "R2";
    chk(line_out == 0, "reset line", line_out, 0);
    chk(fifo_rd == 0, "reset fifo_rd", fifo_rd, 0);
    // R5 R6 R8: two-channel, generated parity, block start in frame 0
    phase("R5", 3, 1, 0, 1, 0, 0, 2, 8, 4, 0);
    // R3: one read per subframe
    phase("R3", 4, 1, 0, 1, 0, 0, 1, 8, 2, 0);
    // R6 R7: copied parity lets the line end high, inverting preambles
    phase("R7", 3, 0, 0, 1, 0, 0, 2, 8, 4, 0);
    phase("R6", 3, 0, 0, 1, 0, 0, 1, 8, 2, 0);
    // R1: clamped and unclamped divider values
    phase("R1", 0, 1, 0, 1, 0, 0, 1, 4, 2, 0);
    phase("R1", 2, 0, 0, 1, 0, 0, 1, 4, 2, 0);
    phase("R1", 6, 1, 0, 1, 0, 0, 1, 4, 2, 0);
    // R8: block start held off two frames
    phase("R8", 3, 1, 0, 1, 1, 2, 4, 10, 8, 0);
    // R9: single-channel, left then right carrying
    phase("R9", 3, 1, 1, 1, 0, 0, 2, 4, 2, 0);
    phase("R9", 3, 0, 1, 0, 0, 0, 2, 4, 2, 0);
    // R4: FIFO runs dry after one word
    phase("R4", 3, 1, 0, 1, 0, 0, 1, 1, 1, 1);
    // R2: receive direction selected, nothing is consumed
    @(posedge clk); #2;
    cur_req = "R2"; fill(4, 99); cfg_tx_mode = 0; cfg_enable = 1; rd_seen = 0;
    repeat (300) @(posedge clk);
    #2 chk(q.size() == 4, "fifo untouched", q.size(), 4);
    chk(rd_seen == 0, "no reads while held", rd_seen, 0);
    cfg_tx_mode = 1;
    repeat (200) @(posedge clk);
    #2 cfg_enable = 0;
    repeat (50) @(posedge clk);
    #2 chk(q.size() == 3, "fifo after short run", q.size(), 3);
    cfg_enable = 1;
    repeat (600) @(posedge clk);
    #2 cfg_enable = 0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule